// File: doc/BRIEF.md
# Horizontal Minimum and Position Finder

This unit receives a 128-bit vector split into eight unsigned 16-bit lanes and finds the smallest lane value and the number of the lane that holds it. Both go into one 128-bit result word. The value sits in the lowest 16 bits and the lane number directly above it. Every other bit of the result is zero.

The caller drives the vector together with a valid strobe for one cycle. The input register captures it, and a reduction tree of pairwise compares feeds the result register. Two clock edges later the result appears with its own one-cycle valid pulse. A new vector may be offered on every cycle. When two lanes hold the same value, the lower-numbered lane always wins.

Top module: `hmin_pos_unit`

## Requirements
- R1: Lane j of `inVec` is bits [16j+15:16j], so lane 0 is at the least significant end and lane 7 at the most significant end.
- R2: `outResult[15:0]` equals the smallest lane value, with all lane values compared as unsigned numbers.
- R3: `outResult[18:16]` holds the number (0 to 7) of a lane whose value equals the reported minimum.
- R4: When several lanes share the minimum, the lowest-numbered of them is reported. If all eight lanes are equal, the reported lane number is 0.
- R5: `outResult[31:19]` and `outResult[127:32]` are always zero.
- R6: A vector is accepted on a rising edge where `inValid` is high. `outValid` is high for exactly one cycle, in the cycle that follows the second rising edge after acceptance. Inputs on consecutive cycles give results on consecutive cycles, in the same order.
- R7: When no vector was accepted two edges earlier, `outValid` stays low and `outResult` keeps its previous value, whatever `inVec` does.
- R8: A synchronous active-high `rst` clears `outValid` and `outResult` to zero and drops any vector that is still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Vector on `inVec` is offered this cycle |
| inVec | input | 128 | Eight unsigned 16-bit lanes |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| outResult | output | 128 | Packed minimum value and lane number |

## Verification
A bad compare direction or a wrong tie preference in the tree shows up as a wrong lane number or value. It appears on the very first result whose vector exercises that case, so the stimulus places the minimum at both ends of the vector, places ties at several positions, and includes values above 0x7FFF. A fault in the valid pipeline shows up as a pulse that comes a cycle early or late, a missing pulse, or a duplicated pulse. A fault in the result enable shows up as `outResult` changing while no pulse is present. Both are visible within two cycles of the offending input or reset.

// File: rtl/hmin_pkg.sv
package hmin_pkg;
  // Strobes sent from the control path to the datapath
  typedef struct packed {
    logic ldIn;   // capture the incoming vector
    logic ldOut;  // capture the reduced result
  } hmin_strobe_t;
endpackage

// File: rtl/hmin_ctrl.sv
module hmin_ctrl
  import hmin_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output hmin_strobe_t strobe,
  output logic         outValid
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobe.ldIn  = inValid;
    strobe.ldOut = stageValid;
  end

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    stageValid |=> outValid);                                   // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !stageValid |=> !outValid);                                 // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !outValid);                                         // R8
endmodule

// File: rtl/hmin_datapath.sv
module hmin_datapath
  import hmin_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  hmin_strobe_t     strobe,
  input  logic [VEC_W-1:0] inVec,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0]  vecReg;
  logic [LANE_W-1:0] laneVal [LANES];
  // Heap-ordered tree: node n combines 2n (lower lanes) and 2n+1 (upper lanes)
  logic [LANE_W-1:0] nodeVal [2*LANES];
  logic [IDX_W-1:0]  nodeIdx [2*LANES];
  logic [VEC_W-1:0]  packed_res;

  always_ff @(posedge clk) begin
    if (rst)              vecReg <= '0;
    else if (strobe.ldIn) vecReg <= inVec;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign laneVal[j] = vecReg[j*LANE_W +: LANE_W];
  end

  always_comb begin
    nodeVal[0] = '0;
    nodeIdx[0] = '0;
    for (int j = 0; j < LANES; j++) begin
      nodeVal[LANES+j] = laneVal[j];
      nodeIdx[LANES+j] = IDX_W'(j);
    end
    for (int n = LANES - 1; n >= 1; n--) begin
      // upper side wins only when strictly smaller: ties go to the lower lane
      if (nodeVal[2*n+1] < nodeVal[2*n]) begin
        nodeVal[n] = nodeVal[2*n+1];
        nodeIdx[n] = nodeIdx[2*n+1];
      end else begin
        nodeVal[n] = nodeVal[2*n];
        nodeIdx[n] = nodeIdx[2*n];
      end
    end
    packed_res = '0;
    packed_res[LANE_W-1:0]             = nodeVal[1];
    packed_res[LANE_W +: IDX_W]        = nodeIdx[1];
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (strobe.ldOut) result <= packed_res;
  end

  function automatic logic [LANE_W-1:0] laneAt(logic [VEC_W-1:0] v, logic [IDX_W-1:0] k);
    return v[k*LANE_W +: LANE_W];
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
      strobe.ldOut |=> result[LANE_W-1:0] <= $past(laneVal[j]));          // R2
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst)
      strobe.ldOut |=> (IDX_W'(j) < result[LANE_W +: IDX_W]) ->
        ($past(laneVal[j]) > result[LANE_W-1:0]));                       // R4
  end

  AST_IDX_HOLDS_MIN: assert property (@(posedge clk) disable iff (rst)
    strobe.ldOut |=> laneAt($past(vecReg), result[LANE_W +: IDX_W]) == result[LANE_W-1:0]); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !strobe.ldOut |=> $stable(result));                                  // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.ldOut |=> result[VEC_W-1:LANE_W+IDX_W] == '0);                // R5
endmodule

// File: rtl/hmin_pos_unit.sv
module hmin_pos_unit
  import hmin_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VEC_W-1:0] inVec,
  output logic             outValid,
  output logic [VEC_W-1:0] outResult
);
  hmin_strobe_t strobe;

  hmin_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hmin_datapath #(.LANES(LANES), .LANE_W(LANE_W)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inVec  (inVec),
    .result (outResult)
  );
endmodule

// File: tb/test_hmin_pos_unit.sv
module test_hmin_pos_unit;
  typedef struct packed {
    logic [127:0] vec;
    logic [15:0]  mn;
    logic [2:0]   ix;
  } vec_case_t;

  // lanes written lane7 ... lane0
  localparam vec_case_t CASES [8] = '{
    '{128'h0006_0002_0008_0007_0001_0009_0003_0005, 16'h0001, 3'd3}, // R2 distinct
    '{128'h0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'h0000, 3'd7}, // R1 top lane
    '{128'h0008_0007_0006_0005_0004_0003_0002_0001, 16'h0001, 3'd0}, // R1 bottom lane
    '{128'h1234_1234_1234_1234_1234_1234_1234_1234, 16'h1234, 3'd0}, // R4 all equal
    '{128'h0090_0010_0080_0070_0060_0010_0050_0040, 16'h0010, 3'd2}, // R4 tie 2 and 6
    '{128'hFFFF_9000_A000_C000_F000_FFFF_7FFF_8000, 16'h7FFF, 3'd1}, // R2 unsigned
    '{128'h0,                                       16'h0000, 3'd0}, // R4 all zero
    '{128'h0000_0001_0000_0002_0003_0004_0005_0006, 16'h0000, 3'd5}  // R4 tie 5 and 7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [127:0] inVec = '0;
  logic outValid;
  logic [127:0] outResult;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hmin_pos_unit i_hmin_pos_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(inVec),
    .outValid(outValid), .outResult(outResult)
  );

  function automatic logic [127:0] expRes(logic [15:0] mn, logic [2:0] ix);
    return {96'b0, 13'b0, ix, mn};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset outValid", {127'b0, outValid}, 128'd0);
    chk("R8 reset outResult", outResult, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // table walk, one vector at a time
    foreach (CASES[k]) begin
      inValid = 1'b1; inVec = CASES[k].vec;
      @(negedge clk);
      inValid = 1'b0; inVec = ~CASES[k].vec;
      chk("R6 no early pulse", {127'b0, outValid}, 128'd0);
      @(negedge clk);
      chk("R6 pulse after two edges", {127'b0, outValid}, 128'd1);
      chk("R2 R3 R5 result", outResult, expRes(CASES[k].mn, CASES[k].ix));
      @(negedge clk);
      chk("R6 single pulse", {127'b0, outValid}, 128'd0);
    end

    // R7: input toggling without valid leaves result untouched
    inVec = 128'h0;
    repeat (3) @(negedge clk);
    chk("R7 no pulse while idle", {127'b0, outValid}, 128'd0);
    chk("R7 result held", outResult, expRes(CASES[7].mn, CASES[7].ix));

    // R6 back-to-back inputs
    inValid = 1'b1; inVec = CASES[0].vec;
    @(negedge clk);
    inVec = CASES[5].vec;
    @(negedge clk);
    inValid = 1'b0; inVec = '0;
    chk("R6 b2b first valid", {127'b0, outValid}, 128'd1);
    chk("R6 b2b first data", outResult, expRes(CASES[0].mn, CASES[0].ix));
    @(negedge clk);
    chk("R6 b2b second valid", {127'b0, outValid}, 128'd1);
    chk("R6 b2b second data", outResult, expRes(CASES[5].mn, CASES[5].ix));
    @(negedge clk);
    chk("R6 b2b ends", {127'b0, outValid}, 128'd0);

    // R8 reset drops in-flight vector
    inValid = 1'b1; inVec = CASES[1].vec;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 cleared result", outResult, 128'd0);
    chk("R8 cleared valid", {127'b0, outValid}, 128'd0);
    @(negedge clk);
    chk("R8 no pulse after reset", {127'b0, outValid}, 128'd0);
    chk("R8 result stays zero", outResult, 128'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule